// File: doc/BRIEF.md
# Cascadable Time-Slot Sample Data Port

This block is the serial sample port of a stereo converter. It lets several converters share one DSP serial port. All logic runs on the serial bit clock. A one-cycle frame pulse marks the start of each frame. A static position input tells each device where it sits in the cascade.

The block has two modes, chosen by `chain_mode`.

- **Time-slot mode:** a device at position P owns two consecutive 16-bit slots.
  - It sends its left and right ADC words in those slots.
  - It collects its left and right DAC words from the shared input line during the same slots.
  - It releases the output line at all other times.
- **Chain mode:** every device loads its two ADC words together on the same frame pulse. It then shifts continuously. It first sends its own 32 bits, then passes on whatever the device upstream of it delivered.

Top module: `tdm_cascade_port`

## Requirements
- R1: After reset, `sdo_en` and `dac_valid` are low, and they stay low until the first frame pulse is sampled.
- R2: `fsync` is sampled on a rising clock edge. Frame bit 0 occupies the cycle after that edge, and frame bit n = 16*s + b is bit b of slot s. A frame holds 2*16*2^POS_W bits. After its last bit the port is idle (`sdo_en` low, no DAC strobe) until the next frame pulse.
- R3: In time-slot mode, a device at position P drives the line in slots 2P (left) and 2P+1 (right). Each word is sent MSB first. `sdo_en` is high exactly in those 32 bit cycles.
- R4: The ADC words are taken from `adc_l`/`adc_r` at the edge that samples the frame pulse. Later changes on those inputs do not alter the frame being sent.
- R5: In time-slot mode, the `sdi` bits of slots 2P and 2P+1 are assembled MSB first. In the cycle after each slot's last bit:
  - `dac_word` holds the assembled word;
  - `dac_chan` is 0 for left and 1 for right;
  - `dac_valid` is high for that single cycle.

  `sdi` outside those slots has no effect.
- R6: In chain mode, `sdo` carries the device's own left then right word (32 bits, MSB first) starting at frame bit 0. From frame bit 32 on, `sdo` repeats `sdi` delayed by 32 cycles. `sdo_en` is high for the whole frame, and the position input has no effect.
- R7: In chain mode, `dac_valid` never rises.
- R8: A frame pulse arriving inside a frame restarts the slot and bit count at frame bit 0 and reloads the ADC words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame start pulse, one cycle wide |
| sdi | input | 1 | Serial input: DAC data in time-slot mode, upstream data in chain mode |
| chain_mode | input | 1 | 0 = time-slot mode, 1 = chain mode |
| slot_pos | input | POS_W | Cascade position of this device |
| adc_l | input | WORD_W | Left ADC result |
| adc_r | input | WORD_W | Right ADC result |
| sdo | output | 1 | Serial output data |
| sdo_en | output | 1 | Output drive enable (low means high impedance) |
| dac_word | output | WORD_W | Last completed DAC word |
| dac_chan | output | 1 | Channel of `dac_word`: 0 left, 1 right |
| dac_valid | output | 1 | One-cycle strobe for `dac_word` |

## Verification
The bench builds the port with the default 16-bit words and a 3-bit position. This gives a full 256-bit frame with eight device positions.

- **Position coverage:** both end positions 0 and 7 are reached, as well as random middle positions. So the first slot, the last slot, and the idle period after the frame end are all exercised.
- **Frame restart:** a second frame pulse is injected partway through a frame, inside the device's own slots, to show the count restarts.
- **Chain mode:** runs long enough for upstream bits to emerge 32 cycles late.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  typedef enum logic {
    MODE_SLOT  = 1'b0,
    MODE_CHAIN = 1'b1
  } port_mode_e;
endpackage

// File: rtl/tcp_frame_timer.sv
module tcp_frame_timer #(
  parameter int WORD_W = 16,
  parameter int POS_W  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   fsync,
  output logic [$clog2(2*WORD_W*(1<<POS_W))-1:0] cnt,
  output logic                                   active,
  output logic [$clog2(2*WORD_W*(1<<POS_W))-1:0] nxt_cnt,
  output logic                                   nxt_active
);
  localparam int FRAME_BITS = 2 * WORD_W * (1 << POS_W);
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = '1;
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt_active = fsync | (active && (cnt != LAST_BIT));
    if (fsync)       nxt_cnt = '0;
    else if (active) nxt_cnt = cnt + ONE;
    else             nxt_cnt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else begin
      cnt    <= nxt_cnt;
      active <= nxt_active;
    end
  end

  // R8
  frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
    fsync |=> (active && cnt == '0));

  // R2
  frame_end_chk: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == LAST_BIT && !fsync) |=> !active);
endmodule

// File: rtl/tcp_tx_shifter.sv
module tcp_tx_shifter #(
  parameter int WORD_W = 16,
  parameter int POS_W  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   fsync,
  input  logic                                   is_chain,
  input  logic [POS_W-1:0]                       slot_pos,
  input  logic [WORD_W-1:0]                      adc_l,
  input  logic [WORD_W-1:0]                      adc_r,
  input  logic                                   sdi,
  input  logic [$clog2(2*WORD_W*(1<<POS_W))-1:0] cnt,
  input  logic                                   active,
  input  logic [$clog2(2*WORD_W*(1<<POS_W))-1:0] nxt_cnt,
  input  logic                                   nxt_active,
  output logic                                   sdo,
  output logic                                   sdo_en
);
  localparam int FRAME_BITS = 2 * WORD_W * (1 << POS_W);
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int PAIR_SH    = $clog2(2 * WORD_W);
  localparam int SR_W       = 2 * WORD_W;

  logic [SR_W-1:0] shreg;
  logic            own_now, own_nxt;

  assign own_now = active     && (cnt[CNT_W-1:PAIR_SH]     == slot_pos);
  assign own_nxt = nxt_active && (nxt_cnt[CNT_W-1:PAIR_SH] == slot_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      sdo_en <= 1'b0;
    end else begin
      sdo_en <= nxt_active && (is_chain || own_nxt);
      if (fsync)
        shreg <= {adc_l, adc_r};
      else if (active && (is_chain || own_now))
        shreg <= {shreg[SR_W-2:0], is_chain ? sdi : 1'b0};
    end
  end

  assign sdo = shreg[SR_W-1];

  // R3
  own_slot_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (sdo_en && !is_chain && $past(!is_chain) && $stable(slot_pos))
      |-> (active && cnt[CNT_W-1:PAIR_SH] == slot_pos));

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !nxt_active |=> !sdo_en);

  // R6
  chain_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (is_chain && active && !fsync) |=> (sdo == $past(shreg[SR_W-2])));
endmodule

// File: rtl/tcp_rx_capture.sv
module tcp_rx_capture #(
  parameter int WORD_W = 16,
  parameter int POS_W  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   is_chain,
  input  logic [POS_W-1:0]                       slot_pos,
  input  logic                                   sdi,
  input  logic [$clog2(2*WORD_W*(1<<POS_W))-1:0] cnt,
  input  logic                                   active,
  output logic [WORD_W-1:0]                      dac_word,
  output logic                                   dac_chan,
  output logic                                   dac_valid
);
  localparam int FRAME_BITS = 2 * WORD_W * (1 << POS_W);
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int BIT_W      = $clog2(WORD_W);
  localparam int PAIR_SH    = BIT_W + 1;

  logic [WORD_W-1:0] rx;
  logic              own_now;
  logic              last_bit;

  assign own_now  = active && (cnt[CNT_W-1:PAIR_SH] == slot_pos);
  assign last_bit = &cnt[BIT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx        <= '0;
      dac_word  <= '0;
      dac_chan  <= 1'b0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= 1'b0;
      if (!is_chain && own_now) begin
        rx <= {rx[WORD_W-2:0], sdi};
        if (last_bit) begin
          dac_word  <= {rx[WORD_W-2:0], sdi};
          dac_chan  <= cnt[BIT_W];
          dac_valid <= 1'b1;
        end
      end
    end
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    dac_valid |=> !dac_valid);

  // R7
  strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    dac_valid |-> $past(!is_chain));
endmodule

// File: rtl/tdm_cascade_port.sv
module tdm_cascade_port
  import tcp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int POS_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              sdi,
  input  logic              chain_mode,
  input  logic [POS_W-1:0]  slot_pos,
  input  logic [WORD_W-1:0] adc_l,
  input  logic [WORD_W-1:0] adc_r,
  output logic              sdo,
  output logic              sdo_en,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_chan,
  output logic              dac_valid
);
  localparam int FRAME_BITS = 2 * WORD_W * (1 << POS_W);
  localparam int CNT_W      = $clog2(FRAME_BITS);

  port_mode_e       mode;
  logic             is_chain;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic             active, nxt_active;

  assign mode     = chain_mode ? MODE_CHAIN : MODE_SLOT;
  assign is_chain = (mode == MODE_CHAIN);

  tcp_frame_timer #(.WORD_W(WORD_W), .POS_W(POS_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .fsync      (fsync),
    .cnt        (cnt),
    .active     (active),
    .nxt_cnt    (nxt_cnt),
    .nxt_active (nxt_active)
  );

  tcp_tx_shifter #(.WORD_W(WORD_W), .POS_W(POS_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .fsync      (fsync),
    .is_chain   (is_chain),
    .slot_pos   (slot_pos),
    .adc_l      (adc_l),
    .adc_r      (adc_r),
    .sdi        (sdi),
    .cnt        (cnt),
    .active     (active),
    .nxt_cnt    (nxt_cnt),
    .nxt_active (nxt_active),
    .sdo        (sdo),
    .sdo_en     (sdo_en)
  );

  tcp_rx_capture #(.WORD_W(WORD_W), .POS_W(POS_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .is_chain  (is_chain),
    .slot_pos  (slot_pos),
    .sdi       (sdi),
    .cnt       (cnt),
    .active    (active),
    .dac_word  (dac_word),
    .dac_chan  (dac_chan),
    .dac_valid (dac_valid)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sdo_en && !dac_valid));
endmodule

// File: tb/tdm_cascade_port_tb.sv
module tdm_cascade_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int PW = 3;
  localparam int FB = 2 * W * (1 << PW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fsync = 1'b0;
  logic          sdi = 1'b0;
  logic          chain_mode = 1'b0;
  logic [PW-1:0] slot_pos = '0;
  logic [W-1:0]  adc_l = '0;
  logic [W-1:0]  adc_r = '0;
  logic          sdo, sdo_en, dac_chan, dac_valid;
  logic [W-1:0]  dac_word;

  int n_vec = 0;
  int n_bad = 0;
  bit sh [0:FB+15];

  tdm_cascade_port #(.WORD_W(W), .POS_W(PW)) u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .sdi(sdi), .chain_mode(chain_mode),
    .slot_pos(slot_pos), .adc_l(adc_l), .adc_r(adc_r), .sdo(sdo),
    .sdo_en(sdo_en), .dac_word(dac_word), .dac_chan(dac_chan),
    .dac_valid(dac_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_dac(input int j);
    logic [W-1:0] v = '0;
    for (int i = 0; i < W; i++) v = {v[W-2:0], sh[j-W+1+i]};
    return v;
  endfunction

  // frame pulse with ADC words; afterwards ADC inputs are scrambled (R4)
  task automatic start_frame(input logic [2*W-1:0] word);
    @(negedge clk);
    adc_l = word[2*W-1:W];
    adc_r = word[W-1:0];
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    adc_l = W'($urandom);
    adc_r = W'($urandom);
  endtask

  // checks frame bits 0..nbits-1 in slot mode; caller is at negedge of bit 0
  task automatic run_slot(input int p, input logic [2*W-1:0] word,
                          input int nbits, input string tag);
    for (int k = 0; k < nbits; k++) begin
      bit own = (k < FB) && (k / (2*W) == p);
      int j = k - 1;
      bit strobe = (j >= 0) && (j < FB) && (j / (2*W) == p) && (j % W == W-1);
      // R2 R3: enable only in own slots, low after frame end
      chk(sdo_en == own, $sformatf("R3 R2 en k=%0d %s", k, tag), sdo_en, own);
      // R3 R4: MSB first, words from the frame pulse edge
      if (own)
        chk(sdo == word[2*W-1-(k % (2*W))], $sformatf("R3 R4 sdo k=%0d %s", k, tag),
            sdo, word[2*W-1-(k % (2*W))]);
      // R5: DAC strobe, word and channel
      chk(dac_valid == strobe, $sformatf("R5 valid k=%0d %s", k, tag), dac_valid, strobe);
      if (strobe) begin
        chk(dac_word == exp_dac(j), $sformatf("R5 word k=%0d %s", k, tag), dac_word, exp_dac(j));
        chk(dac_chan == ((j / W) % 2 == 1), $sformatf("R5 chan k=%0d %s", k, tag),
            dac_chan, (j / W) % 2);
      end
      sdi = 1'($urandom);
      sh[k] = sdi;
      @(negedge clk);
    end
  endtask

  // R6 R7: chain mode
  task automatic run_chain(input logic [2*W-1:0] word, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      bit e = (k < 2*W) ? word[2*W-1-k] : sh[k-2*W];
      chk(sdo_en == 1'b1, $sformatf("R6 en k=%0d", k), sdo_en, 1);
      chk(sdo == e, $sformatf("R6 sdo k=%0d", k), sdo, e);
      chk(dac_valid == 1'b0, $sformatf("R7 valid k=%0d", k), dac_valid, 0);
      sdi = 1'($urandom);
      sh[k] = sdi;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [2*W-1:0] w;
    void'($urandom(32'd7117));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset and before any frame pulse
    for (int i = 0; i < 6; i++) begin
      sdi = 1'($urandom);
      chk(!sdo_en, "R1 en", sdo_en, 0);
      chk(!dac_valid, "R1 valid", dac_valid, 0);
      @(negedge clk);
    end

    // directed end positions, frame end included
    chain_mode = 1'b0;
    slot_pos = 3'd0;
    w = 32'hA5C3_1E0F;
    start_frame(w);
    run_slot(0, w, FB + 3, "pos0");
    slot_pos = 3'd7;
    w = 32'h8001_7FFE;
    start_frame(w);
    run_slot(7, w, FB + 3, "pos7");

    // random positions
    for (int it = 0; it < 6; it++) begin
      int p = int'($urandom % (1 << PW));
      slot_pos = PW'(p);
      w = $urandom;
      start_frame(w);
      run_slot(p, w, FB + 2, "rand");
    end

    // R8: restart inside own slot, then a full checked frame
    slot_pos = 3'd1;
    w = $urandom;
    start_frame(w);
    run_slot(1, w, 40, "R8 pre");
    w = $urandom;
    start_frame(w);
    run_slot(1, w, FB + 2, "R8 post");

    // chain mode, position must not matter
    chain_mode = 1'b1;
    slot_pos = 3'd5;
    w = $urandom;
    start_frame(w);
    run_chain(w, 100);
    slot_pos = 3'd0;
    w = $urandom;
    start_frame(w);
    run_chain(w, 80);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule